// File: doc/BRIEF.md
# Sequential Right-Shift Multiply-Accumulator

This block computes `p = a*x + y` for K-bit operands over K clock cycles. The result is 2K bits wide. It keeps one 2K-bit shift register. The upper half holds the running partial sum. The lower half starts out holding the multiplier `x` and fills with product bits as `x` is shifted out. On each busy cycle the least significant bit of that register chooses between adding `a` or zero into the upper half. The whole register then moves right by one bit. The adder's top bit becomes the new most significant bit, so one multiplier bit costs exactly one clock.

The addend `y` is preloaded into the upper half, so it emerges in the final result with weight one. A mode input selects between unsigned and two's-complement arithmetic:

- In two's-complement mode the partial sum is sign-extended through each shift.
- The last multiplier bit carries a negative weight, so that step subtracts `a`. It does this by inverting `a` and forcing the adder carry-in.

A caller raises `start` while the block is idle. It then waits for the single-cycle `done` pulse and reads `product`, which holds its value until the next accepted start.

Top module: `shift_mac`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` seen at a rising edge while `busy` is 0 captures `a`, `x`, `y` and `is_signed`, and `busy` reads 1 after that edge.
- R3: Exactly K iterations follow the capturing edge. `done` is 1 for exactly one cycle, beginning at the K-th edge after the capturing edge, and `busy` falls at that same edge.
- R4: With `is_signed` = 0, `product` equals the unsigned value a*x + y, with all three operands taken as unsigned K-bit numbers.
- R5: With `is_signed` = 1, `product` equals a*x + y as a 2K-bit two's-complement value. Here `a`, `x` and `y` are K-bit two's-complement numbers, and `y` is sign-extended.
- R6: In signed mode, bit K-1 of `x` weighs -2^(K-1). This holds for the most negative `x`, and for `x` equal to all ones, which means -1.
- R7: While `busy` is 1, `start` and changes on `a`, `x`, `y` and `is_signed` have no effect on the result or on the timing of `done`.
- R8: Once `done` has pulsed, `product` stays unchanged while the block is idle and no `start` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| is_signed | input | 1 | 1 selects two's-complement operands, 0 unsigned |
| a | input | K | Multiplicand |
| x | input | K | Multiplier |
| y | input | K | Addend |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2K | Result a*x + y; intermediate while busy |

## Verification
The assertions rely on inputs being stable around the rising edge, and on reset being applied before the first operation. The assertions on the operand and mode registers assume nothing about `start` during a run, because the block must ignore it. The bench drives every input on the falling edge only. It deliberately raises `start` and toggles the operands and mode in the middle of a run, which tests that the captured values hold. It also sweeps a small instance exhaustively, so every operand combination and both modes are covered.

// File: rtl/shift_mac.sv
module shift_mac #(
  parameter int K = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic [K-1:0]   a,
  input  logic [K-1:0]   x,
  input  logic [K-1:0]   y,
  output logic           busy,
  output logic           done,
  output logic [2*K-1:0] product
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(K - 1);

  logic [K-1:0]  acc_hi, acc_lo, mcand;
  logic          mode_q, busy_q, done_q;
  logic [CW-1:0] iter;

  wire accept  = start & ~busy_q;
  wire is_last = (iter == LAST_IDX);
  wire take    = acc_lo[0];
  wire negate  = mode_q & is_last & take;

  wire [K-1:0] addend = take ? (negate ? ~mcand : mcand) : '0;
  wire [K:0]   sum    = {mode_q & acc_hi[K-1], acc_hi}
                      + {mode_q & addend[K-1], addend}
                      + {{K{1'b0}}, negate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      mcand  <= '0;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        acc_hi <= y;
        acc_lo <= x;
        mcand  <= a;
        mode_q <= is_signed;
        busy_q <= 1'b1;
        iter   <= '0;
      end else if (busy_q) begin
        acc_hi <= sum[K:1];
        acc_lo <= {sum[0], acc_lo[K-1:1]};
        iter   <= iter + 1'b1;
        if (is_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = {acc_hi, acc_lo};

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && iter == '0);

  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && is_last |=> done_q && !busy_q);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_frozen_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mcand) && $stable(mode_q));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> $stable(product));
endmodule

// File: tb/shift_mac_bench.sv
module shift_mac_bench;
  localparam int K  = 8;
  localparam int KS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           start = 0, sg = 0;
  logic [K-1:0]   a = 0, x = 0, y = 0;
  logic           busy, done;
  logic [2*K-1:0] product;

  logic            s_start = 0, s_sg = 0;
  logic [KS-1:0]   s_a = 0, s_x = 0, s_y = 0;
  logic            s_busy, s_done;
  logic [2*KS-1:0] s_product;

  int checks = 0;
  int errors = 0;

  shift_mac #(.K(K)) u_shift_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(sg),
    .a(a), .x(x), .y(y), .busy(busy), .done(done), .product(product));

  shift_mac #(.K(KS)) u_small (
    .clk(clk), .rst_n(rst_n), .start(s_start), .is_signed(s_sg),
    .a(s_a), .x(s_x), .y(s_y), .busy(s_busy), .done(s_done), .product(s_product));

  function automatic logic [2*K-1:0] model(logic [K-1:0] ma, logic [K-1:0] mx,
                                           logic [K-1:0] my, logic ms);
    logic [2*K-1:0] ea, ex, ey;
    ea = ms ? {{K{ma[K-1]}}, ma} : {{K{1'b0}}, ma};
    ex = ms ? {{K{mx[K-1]}}, mx} : {{K{1'b0}}, mx};
    ey = ms ? {{K{my[K-1]}}, my} : {{K{1'b0}}, my};
    return ea * ex + ey;
  endfunction

  function automatic logic [2*KS-1:0] model_s(logic [KS-1:0] ma, logic [KS-1:0] mx,
                                              logic [KS-1:0] my, logic ms);
    logic [2*KS-1:0] ea, ex, ey;
    ea = ms ? {{KS{ma[KS-1]}}, ma} : {{KS{1'b0}}, ma};
    ex = ms ? {{KS{mx[KS-1]}}, mx} : {{KS{1'b0}}, mx};
    ey = ms ? {{KS{my[KS-1]}}, my} : {{KS{1'b0}}, my};
    return ea * ex + ey;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [K-1:0] ra, input logic [K-1:0] rx,
                     input logic [K-1:0] ry, input logic rs, input bit disturb,
                     output logic [2*K-1:0] res, output int lat);
    @(negedge clk);
    a = ra; x = rx; y = ry; sg = rs; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 100) begin
      if (disturb && lat == 2) begin
        start = 1; a = ~ra; x = ~rx; y = ~ry; sg = ~rs;
      end
      @(negedge clk);
      lat++;
    end
    start = 0;
    res = product;
  endtask

  task automatic t_reset();
    check(!busy && !done && product == '0, "R1", {busy, done, product}, 0);
  endtask

  task automatic t_launch_latency();
    logic [2*K-1:0] r; int lat;
    @(negedge clk);
    a = 8'd3; x = 8'd5; y = 8'd1; sg = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R2", busy, 1);
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == K + 1, "R3 latency", lat, K + 1);
    check(!busy, "R3 busy falls", busy, 0);
    r = product;
    check(r == 16'd16, "R4 3*5+1", r, 16);
    @(negedge clk);
    check(!done, "R3 single pulse", done, 0);
  endtask

  task automatic t_unsigned();
    logic [2*K-1:0] r; int lat;
    logic [K-1:0] va [6] = '{8'h00, 8'hFF, 8'hFF, 8'h80, 8'h01, 8'hA5};
    logic [K-1:0] vx [6] = '{8'hFF, 8'hFF, 8'h00, 8'h80, 8'hFF, 8'h3C};
    logic [K-1:0] vy [6] = '{8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'h00, 8'h99};
    for (int i = 0; i < 6; i++) begin
      run(va[i], vx[i], vy[i], 1'b0, 1'b0, r, lat);
      check(r == model(va[i], vx[i], vy[i], 1'b0), "R4 unsigned corner", r,
            model(va[i], vx[i], vy[i], 1'b0));
    end
  endtask

  task automatic t_signed();
    logic [2*K-1:0] r; int lat;
    logic [K-1:0] va [6] = '{8'h80, 8'h80, 8'hFF, 8'h7F, 8'h80, 8'h05};
    logic [K-1:0] vx [6] = '{8'h80, 8'h7F, 8'hFF, 8'h80, 8'h01, 8'hFD};
    logic [K-1:0] vy [6] = '{8'h80, 8'h7F, 8'hFF, 8'h00, 8'h80, 8'h03};
    for (int i = 0; i < 6; i++) begin
      run(va[i], vx[i], vy[i], 1'b1, 1'b0, r, lat);
      check(r == model(va[i], vx[i], vy[i], 1'b1), "R5 signed corner", r,
            model(va[i], vx[i], vy[i], 1'b1));
    end
    run(8'd7, 8'h80, 8'd0, 1'b1, 1'b0, r, lat);
    check(r == 16'hFC80, "R6 x=-128 weight", r, 16'hFC80);
    run(8'd9, 8'hFF, 8'd0, 1'b1, 1'b0, r, lat);
    check(r == 16'hFFF7, "R6 x=-1", r, 16'hFFF7);
  endtask

  task automatic t_ignore_busy();
    logic [2*K-1:0] r; int lat;
    run(8'h5A, 8'hC3, 8'h11, 1'b1, 1'b1, r, lat);
    check(r == model(8'h5A, 8'hC3, 8'h11, 1'b1), "R7 inputs ignored", r,
          model(8'h5A, 8'hC3, 8'h11, 1'b1));
    check(lat == K + 1, "R7 timing kept", lat, K + 1);
  endtask

  task automatic t_hold();
    logic [2*K-1:0] r; int lat;
    run(8'h21, 8'h43, 8'h65, 1'b0, 1'b0, r, lat);
    a = 8'hFF; x = 8'hFF; y = 8'hFF; sg = 1;
    repeat (5) @(negedge clk);
    check(product == r && !done && !busy, "R8 held", product, r);
  endtask

  task automatic t_random();
    logic [2*K-1:0] r; int lat;
    logic [K-1:0] ra, rx, ry; logic rs;
    for (int i = 0; i < 400; i++) begin
      ra = K'($urandom); rx = K'($urandom); ry = K'($urandom); rs = 1'($urandom);
      run(ra, rx, ry, rs, 1'b0, r, lat);
      check(r == model(ra, rx, ry, rs), rs ? "R5 random" : "R4 random", r,
            model(ra, rx, ry, rs));
    end
  endtask

  task automatic t_exhaustive_small();
    logic [2*KS-1:0] exp_v;
    int lat;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            s_a = KS'(i); s_x = KS'(j); s_y = KS'(k); s_sg = 1'(m); s_start = 1;
            @(negedge clk);
            s_start = 0;
            lat = 1;
            while (!s_done && lat < 100) begin @(negedge clk); lat++; end
            exp_v = model_s(KS'(i), KS'(j), KS'(k), 1'(m));
            check(s_product == exp_v, m ? "R5 exhaustive" : "R4 exhaustive",
                  s_product, exp_v);
          end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_launch_latency();
    t_unsigned();
    t_signed();
    t_ignore_busy();
    t_hold();
    t_random();
    t_exhaustive_small();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule